// File: doc/BRIEF.md
# Synthesiser Programming Serial Slave

This block is the serial control port of a frequency synthesiser. An I2C master programs it: the 15-bit divider word for the RF loop, a 5-bit reference ratio code, a 2-bit test-mode field, a 2-bit pump-current field, two reference-output controls and four switch-port states. It also returns a one-byte status that reports a power-on flag and the loop lock state. The bus lines are sampled with the system clock. START and STOP are recognised from SDA edges that occur while SCL is high.

After a matching address, data bytes arrive in pairs. The first bit of the leading byte of a pair sets the kind of pair. A leading 0 opens a frequency pair and a leading 1 opens a control pair. Any number of pairs may follow one address. The upper seven frequency bits are held in a staging register. The divider word therefore changes in one step, either when the low byte arrives or at the STOP that ends the transfer. A read returns the status byte repeatedly for as long as the master acknowledges each byte.

Top module: `synth_prog_i2c`

## Requirements
- R1: After reset: freq_word = 0, ref_code = 0, test_mode = 0, pump_cur = 0, port_out = 0 (ports off), refout_en = 1, refout_sel = 1, and SDA is not driven (sda_oe = 0).
- R2: The address byte is 1,1,0,0,0,addr_sel[1],addr_sel[0],rw, MSB first. The block acknowledges only a match. It ignores all data of a non-matching transfer until the next START.
- R3: In a write transfer every complete data byte is acknowledged: sda_oe = 1 during the ninth SCL pulse.
- R4: A leading byte with bit 7 = 0 carries freq_word[14:8] in bits 6..0. The following byte carries freq_word[7:0]. freq_word does not change until that second byte is complete.
- R5: A leading byte with bit 7 = 1 sets test_mode = bits 6..5 and ref_code = bits 4..0. The following byte sets pump_cur = bits 7..6, refout_en = bit 5, refout_sel = bit 4 and port_out = bits 3..0.
- R6: Pairs repeat without a new address. The second byte of a pair is decoded by its position, whatever its bit 7.
- R7: A STOP after the upper frequency byte, with no lower byte, sets freq_word = {staged bits 14..8, previous bits 7..0}.
- R8: A STOP inside a byte discards the partial byte and leaves every output register unchanged.
- R9: In a read transfer the block sends {por_flag, lock_i, 000000} MSB first. It sends the byte again after each master acknowledge.
- R10: When the master does not acknowledge a status byte, the block releases SDA. It drives nothing more until the next START.
- R11: por_flag is set by reset and by por_evt_i. It is cleared by the STOP that ends a read transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 2 | Variable address bits |
| lock_i | input | 1 | Loop lock indication |
| por_evt_i | input | 1 | Supply-drop event, sets the power-on flag |
| freq_word | output | 15 | RF divider word |
| ref_code | output | 5 | Reference ratio code |
| test_mode | output | 2 | Test-mode field |
| pump_cur | output | 2 | Pump current field |
| refout_en | output | 1 | Reference output enable |
| refout_sel | output | 1 | Reference output select |
| port_out | output | 4 | Switch-port states, 1 = on |

## Verification
The bench builds the block with its defaults: a two-stage line synchroniser and device identifier 11000. A bench quarter-bit of ten system clocks then leaves wide margin over the three-cycle path from an SCL edge to a change on SDA. The bench strap is addr_sel = 10, so a strap mismatch can be produced with address 0xC0 while 0xC4 and 0xC5 match. With these values the bench reaches:
- frequency and control pairs chained in one transfer;
- a STOP that falls between bytes and one that falls inside a byte;
- a status read that the master ends with a missing acknowledge.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
  localparam int BYTE_W = 8;
  localparam int FREQ_W = 15;
  localparam int HI_W   = FREQ_W - BYTE_W;
  localparam int REF_W  = 5;
  localparam int PORT_W = 4;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_WRITE,
    BUS_READ
  } bus_state_t;

  typedef enum logic [1:0] {
    PAIR_HEAD,
    PAIR_FREQ_LO,
    PAIR_CTRL_LO
  } pair_state_t;

  function automatic logic [BYTE_W-1:0] status_byte(input logic por, input logic lock);
    return {por, lock, {(BYTE_W-2){1'b0}}};
  endfunction
endpackage

// File: rtl/synprog_line_sync.sv
module synprog_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end
  end

  always_comb begin
    scl_lvl   = scl_sh[SYNC_STAGES-1];
    sda_lvl   = sda_sh[SYNC_STAGES-1];
    scl_rise  = scl_lvl & ~scl_d;
    scl_fall  = ~scl_lvl & scl_d;
    start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
  end
endmodule

// File: rtl/synprog_bus_fsm.sv
module synprog_bus_fsm
  import synprog_pkg::*;
#(
  parameter logic [4:0] DEV_ID = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] status,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              frame_start,
  output logic              frame_stop,
  output logic              rd_end
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

  bus_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, tx;
  logic              ack_pend, mack, rw_q, rd_sess;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {shreg[BYTE_W-2:0], sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= BUS_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      tx          <= '0;
      ack_pend    <= 1'b0;
      mack        <= 1'b0;
      rw_q        <= 1'b0;
      rd_sess     <= 1'b0;
      sda_oe      <= 1'b0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      frame_start <= 1'b0;
      frame_stop  <= 1'b0;
      rd_end      <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      frame_start <= 1'b0;
      frame_stop  <= 1'b0;
      rd_end      <= 1'b0;
      if (start_det) begin
        state       <= BUS_ADDR;
        bitcnt      <= '0;
        sda_oe      <= 1'b0;
        ack_pend    <= 1'b0;
        frame_start <= 1'b1;
      end else if (stop_det) begin
        state      <= BUS_IDLE;
        bitcnt     <= '0;
        sda_oe     <= 1'b0;
        ack_pend   <= 1'b0;
        frame_stop <= 1'b1;
        rd_end     <= rd_sess;
        rd_sess    <= 1'b0;
      end else if (state != BUS_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < CNT_LAST) begin
            shreg  <= byte_in;
            bitcnt <= bitcnt + CNT_W'(1);
            if (bitcnt == CNT_LAST - CNT_W'(1)) begin
              case (state)
                BUS_ADDR: begin
                  if (byte_in[7:3] == DEV_ID && byte_in[2:1] == addr_sel) begin
                    ack_pend <= 1'b1;
                    rw_q     <= byte_in[0];
                  end else begin
                    state <= BUS_IDLE;
                  end
                end
                BUS_WRITE: begin
                  ack_pend <= 1'b1;
                  rx_byte  <= byte_in;
                  rx_valid <= 1'b1;
                end
                default: ;
              endcase
            end
          end else if (bitcnt == CNT_LAST) begin
            bitcnt <= CNT_ACK;
            mack   <= ~sda_lvl;
          end
        end else if (scl_fall) begin
          if (bitcnt == CNT_LAST) begin
            sda_oe <= ack_pend;
          end else if (bitcnt == CNT_ACK) begin
            bitcnt   <= '0;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
            if ((state == BUS_ADDR && rw_q) || (state == BUS_READ && mack)) begin
              state   <= BUS_READ;
              rd_sess <= 1'b1;
              sda_oe  <= ~status[BYTE_W-1];
              tx      <= {status[BYTE_W-2:0], 1'b0};
            end else if (state == BUS_ADDR) begin
              state <= BUS_WRITE;
            end else if (state == BUS_READ) begin
              state <= BUS_IDLE;
            end
          end else if (state == BUS_READ && bitcnt != '0) begin
            sda_oe <= ~tx[BYTE_W-1];
            tx     <= {tx[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/synprog_regs.sv
module synprog_regs
  import synprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  input  logic              frame_start,
  input  logic              frame_stop,
  input  logic              rd_end,
  input  logic              por_evt,
  output logic              por_flag,
  output logic [FREQ_W-1:0] freq_word,
  output logic [REF_W-1:0]  ref_code,
  output logic [1:0]        test_mode,
  output logic [1:0]        pump_cur,
  output logic              refout_en,
  output logic              refout_sel,
  output logic [PORT_W-1:0] port_out
);
  pair_state_t     pstate;
  logic [HI_W-1:0] hi_stage;
  logic            hi_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pstate     <= PAIR_HEAD;
      hi_stage   <= '0;
      hi_pend    <= 1'b0;
      freq_word  <= '0;
      ref_code   <= '0;
      test_mode  <= '0;
      pump_cur   <= '0;
      refout_en  <= 1'b1;
      refout_sel <= 1'b1;
      port_out   <= '0;
    end else if (rx_valid) begin
      case (pstate)
        PAIR_HEAD: begin
          if (!rx_byte[BYTE_W-1]) begin
            hi_stage <= rx_byte[HI_W-1:0];
            hi_pend  <= 1'b1;
            pstate   <= PAIR_FREQ_LO;
          end else begin
            test_mode <= rx_byte[6:5];
            ref_code  <= rx_byte[REF_W-1:0];
            pstate    <= PAIR_CTRL_LO;
          end
        end
        PAIR_FREQ_LO: begin
          freq_word <= {hi_stage, rx_byte};
          hi_pend   <= 1'b0;
          pstate    <= PAIR_HEAD;
        end
        default: begin
          pump_cur   <= rx_byte[7:6];
          refout_en  <= rx_byte[5];
          refout_sel <= rx_byte[4];
          port_out   <= rx_byte[PORT_W-1:0];
          pstate     <= PAIR_HEAD;
        end
      endcase
    end else if (frame_stop) begin
      pstate <= PAIR_HEAD;
      if (hi_pend) begin
        freq_word <= {hi_stage, freq_word[BYTE_W-1:0]};
        hi_pend   <= 1'b0;
      end
    end else if (frame_start) begin
      pstate <= PAIR_HEAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || por_evt) por_flag <= 1'b1;
    else if (rd_end)    por_flag <= 1'b0;
  end
endmodule

// File: rtl/synth_prog_i2c.sv
module synth_prog_i2c
  import synprog_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] DEV_ID      = 5'b11000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  input  logic              por_evt_i,
  output logic [FREQ_W-1:0] freq_word,
  output logic [REF_W-1:0]  ref_code,
  output logic [1:0]        test_mode,
  output logic [1:0]        pump_cur,
  output logic              refout_en,
  output logic              refout_sel,
  output logic [PORT_W-1:0] port_out
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] rx_byte, status;
  logic rx_valid, frame_start, frame_stop, rd_end, por_flag;

  assign status = status_byte(por_flag, lock_i);

  synprog_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  synprog_bus_fsm #(.DEV_ID(DEV_ID)) u_fsm (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .status(status), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .frame_start(frame_start),
    .frame_stop(frame_stop), .rd_end(rd_end)
  );

  synprog_regs u_regs (
    .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .frame_start(frame_start), .frame_stop(frame_stop), .rd_end(rd_end),
    .por_evt(por_evt_i), .por_flag(por_flag), .freq_word(freq_word),
    .ref_code(ref_code), .test_mode(test_mode), .pump_cur(pump_cur),
    .refout_en(refout_en), .refout_sel(refout_sel), .port_out(port_out)
  );
endmodule

// File: rtl/synprog_chk.sv
module synprog_chk
  import synprog_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_lvl,
  input logic              stop_det,
  input logic              rx_valid,
  input logic              frame_stop,
  input logic              por_evt_i,
  input logic              por_flag,
  input logic [FREQ_W-1:0] freq_word,
  input logic [PORT_W-1:0] port_out,
  input logic              refout_en,
  input logic              refout_sel
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: defaults are visible in the first cycle after reset
  always @(posedge clk) begin
    if (rst_d === 1'b1 && rst === 1'b0) begin
      assert_reset_defaults_R1: assert (port_out == '0 && refout_en && refout_sel && freq_word == '0 && !sda_oe);
    end
  end

  // R3: SDA is only taken while the synchronised SCL is low
  assert_drive_on_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  // R4 / R7: divider word moves only on a received byte or a STOP
  assert_freq_atomic_R4: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !frame_stop) |=> $stable(freq_word));

  // R8: ports move only on a complete received byte
  assert_ports_on_byte_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(port_out));

  // R10: a STOP always frees the data line
  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R11: a supply-drop event sets the power-on flag
  assert_por_set_R11: assert property (@(posedge clk) disable iff (rst)
    por_evt_i |=> por_flag);
endmodule

bind synth_prog_i2c synprog_chk u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
  .stop_det(stop_det), .rx_valid(rx_valid), .frame_stop(frame_stop),
  .por_evt_i(por_evt_i), .por_flag(por_flag), .freq_word(freq_word),
  .port_out(port_out), .refout_en(refout_en), .refout_sel(refout_sel)
);

// File: tb/tb_synth_prog_i2c.sv
module tb_synth_prog_i2c;
  localparam int QTR = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b10;
  logic lock_i = 1'b0, por_evt_i = 1'b0;
  logic sda_oe, refout_en, refout_sel;
  logic [14:0] freq_word;
  logic [4:0] ref_code;
  logic [1:0] test_mode, pump_cur;
  logic [3:0] port_out;
  logic sda_bus;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;
  always #5 clk = ~clk;

  synth_prog_i2c dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .por_evt_i(por_evt_i),
    .freq_word(freq_word), .ref_code(ref_code), .test_mode(test_mode),
    .pump_cur(pump_cur), .refout_en(refout_en), .refout_sel(refout_sel),
    .port_out(port_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(QTR);
    sda_m = 1'b0; wait_clk(QTR);
    scl_m = 1'b0; wait_clk(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(QTR);
    scl_m = 1'b1; wait_clk(QTR);
    sda_m = 1'b1; wait_clk(2*QTR);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    sda_m = b; wait_clk(QTR);
    scl_m = 1'b1; wait_clk(QTR);
    s = sda_bus; wait_clk(QTR);
    scl_m = 1'b0; wait_clk(QTR);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      v[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  task automatic t_reset_state();
    chk(freq_word == 15'd0, "R1 freq_word", freq_word, 0);
    chk(ref_code == 5'd0 && test_mode == 2'd0 && pump_cur == 2'd0, "R1 ref/test/pump",
        {ref_code, test_mode, pump_cur}, 0);
    chk(port_out == 4'd0, "R1 port_out", port_out, 0);
    chk(refout_en && refout_sel, "R1 refout", {refout_en, refout_sel}, 3);
    chk(!sda_oe, "R1 sda_oe", sda_oe, 0);
  endtask

  task automatic t_first_read();
    logic a; logic [7:0] v;
    bus_start();
    send_byte(8'hC5, a);
    chk(a, "R2 read address ack", a, 1);
    recv_byte(1'b0, v);
    chk(v == 8'h80, "R9 R11 status after reset", v, 8'h80);
    chk(!sda_oe, "R10 released after no-ack", sda_oe, 0);
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R10 silent after no-ack", v, 8'hFF);
    bus_stop();
    bus_start();
    send_byte(8'hC5, a);
    recv_byte(1'b0, v);
    bus_stop();
    chk(v == 8'h00, "R11 flag cleared by read STOP", v, 8'h00);
  endtask

  task automatic t_freq_pair();
    logic a;
    bus_start();
    send_byte(8'hC4, a);
    chk(a, "R2 write address ack", a, 1);
    send_byte(8'h35, a);
    chk(a, "R3 ack of upper byte", a, 1);
    chk(freq_word == 15'd0, "R4 word held until low byte", freq_word, 0);
    send_byte(8'hA7, a);
    chk(a, "R3 ack of lower byte", a, 1);
    chk(freq_word == 15'h35A7, "R4 word after pair", freq_word, 15'h35A7);
    bus_stop();
  endtask

  task automatic t_ctrl_chain();
    logic a;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'hCB, a);
    chk(test_mode == 2'd2 && ref_code == 5'h0B, "R5 control head", {test_mode, ref_code}, {2'd2, 5'h0B});
    send_byte(8'h9A, a);
    chk(pump_cur == 2'd2 && !refout_en && refout_sel, "R5 pump/refout",
        {pump_cur, refout_en, refout_sel}, {2'd2, 1'b0, 1'b1});
    chk(port_out == 4'hA, "R5 ports", port_out, 4'hA);
    send_byte(8'h12, a);
    chk(freq_word == 15'h35A7, "R6 chained pair held", freq_word, 15'h35A7);
    send_byte(8'hFF, a);
    chk(a, "R3 ack in chain", a, 1);
    chk(freq_word == 15'h12FF, "R6 second byte by position", freq_word, 15'h12FF);
    bus_stop();
  endtask

  task automatic t_stop_commit();
    logic a;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'h05, a);
    chk(freq_word == 15'h12FF, "R7 before STOP", freq_word, 15'h12FF);
    bus_stop();
    chk(freq_word == 15'h05FF, "R7 committed at STOP", freq_word, 15'h05FF);
  endtask

  task automatic t_partial_stop();
    logic a, s;
    bus_start();
    send_byte(8'hC4, a);
    send_byte(8'hE3, a);
    clock_bit(1'b0, s);
    clock_bit(1'b1, s);
    clock_bit(1'b0, s);
    bus_stop();
    chk(test_mode == 2'd3 && ref_code == 5'd3, "R8 head byte kept", {test_mode, ref_code}, {2'd3, 5'd3});
    chk(port_out == 4'hA && pump_cur == 2'd2 && !refout_en, "R8 partial byte dropped",
        {port_out, pump_cur, refout_en}, {4'hA, 2'd2, 1'b0});
    chk(freq_word == 15'h05FF, "R8 word unchanged", freq_word, 15'h05FF);
  endtask

  task automatic t_foreign_addr();
    logic a;
    bus_start();
    send_byte(8'hC0, a);
    chk(!a, "R2 no ack on strap mismatch", a, 0);
    send_byte(8'h01, a);
    chk(!a, "R2 no ack on ignored data", a, 0);
    send_byte(8'h02, a);
    bus_stop();
    chk(freq_word == 15'h05FF, "R2 ignored write", freq_word, 15'h05FF);
  endtask

  task automatic t_status_chain();
    logic a; logic [7:0] v;
    lock_i = 1'b1;
    @(negedge clk); por_evt_i = 1'b1;
    @(negedge clk); por_evt_i = 1'b0;
    bus_start();
    send_byte(8'hC5, a);
    recv_byte(1'b1, v);
    chk(v == 8'hC0, "R9 status with flag and lock", v, 8'hC0);
    recv_byte(1'b0, v);
    chk(v == 8'hC0, "R9 repeated after master ack", v, 8'hC0);
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R10 no drive after no-ack", v, 8'hFF);
    bus_stop();
    bus_start();
    send_byte(8'hC5, a);
    recv_byte(1'b0, v);
    bus_stop();
    chk(v == 8'h40, "R11 cleared, lock shown", v, 8'h40);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    t_reset_state();
    t_first_read();
    t_freq_pair();
    t_ctrl_chain();
    t_stop_commit();
    t_partial_stop();
    t_foreign_addr();
    t_status_chain();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule